// File: doc/BRIEF.md
# Two-Way FIFO Cache Tag Directory

This block is the tag side of a small two-way set-associative cache. Each clock cycle it can take one byte address. In the same cycle it reports whether the line holding that byte is present, which set the address indexes, and which way is involved. For a hit, the way is the one holding the line. For a miss, the way is the one being allocated. A miss is treated as an immediate fill, so the directory takes in the new tag at the clock edge that ends the lookup. The data array, transfers from backing memory, write policy and dirty state belong to other blocks.

Replacement within a set follows fill order, not use order. Every set runs a small state machine:

- `SET_EMPTY`: no valid way.
- `SET_HALF`: only way 0 is valid.
- `SET_FULL_V0`: both ways are valid and way 0 is the next victim.
- `SET_FULL_V1`: both ways are valid and way 1 is the next victim.

Only a miss moves a set to another state. The transitions are `SET_EMPTY`→`SET_HALF` (fill way 0), `SET_HALF`→`SET_FULL_V0` (fill way 1), `SET_FULL_V0`→`SET_FULL_V1` (replace way 0) and `SET_FULL_V1`→`SET_FULL_V0` (replace way 1). A hit leaves the set in its current state.

Two saturating 32-bit counters record hits and misses over time. A clear input sets both to zero.

Top module: `fifo_tag_dir`

## Requirements
- R1: The 15-bit address splits into a tag in bits 14:5, a set index in bits 4:3 and a byte offset in bits 2:0. `set_idx` shows bits 4:3 of the current address.
- R2: A request is a hit when its tag equals the tag of a valid way in the indexed set, whatever the byte offset. On a hit, `way` names the matching way.
- R3: When `req_valid` is 1, exactly one of `hit` and `miss` is 1, in the same cycle as the request. When `req_valid` is 0, both are 0 and `way` is 0.
- R4: In an empty set, the first miss fills way 0 and the second miss fills way 1. `way` reports the way being filled.
- R5: A miss to a set with both ways valid replaces the way that was filled earliest, and `way` reports that way. A byte sweep over 0x00–0x43 repeated four times gives 254 hits and 18 misses.
- R6: A hit never changes which way a set will replace next.
- R7: A miss only alters the set it indexes. Lines in other sets stay present.
- R8: A synchronous active-high `rst` empties every set and sets both counters to zero.
- R9: `hit_count` and `miss_count` each increase by one per hit or miss request. They saturate at all ones and hold their value in idle cycles.
- R10: `clear_stats` sets both counters to zero at the next edge. It takes priority over an increment requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A lookup is requested this cycle |
| addr | input | 15 | Byte address of the lookup |
| clear_stats | input | 1 | Sets both counters to zero |
| hit | output | 1 | The lookup found the line |
| miss | output | 1 | The lookup did not find the line; a way is allocated |
| set_idx | output | 2 | Set indexed by the address |
| way | output | 1 | Matching way on a hit, allocated way on a miss |
| hit_count | output | 32 | Saturating count of hits |
| miss_count | output | 32 | Saturating count of misses |

## Verification
`hit`, `miss`, `set_idx` and `way` are combinational from the request. The bench drives each request on a falling edge and samples these outputs one nanosecond later, before the next rising edge. Directory state and the counters change at the rising edge that ends the request, so counter values are read at the following falling edge and fill effects appear on the next request. A reference model in the bench, built from the fill-order rule, predicts every lookup during a four-pass byte sweep. Directed sequences cover eviction after a hit, cross-set isolation, a clear that coincides with a request, and a reset in the middle of a run.

// File: rtl/fdir_pkg.sv
package fdir_pkg;

    localparam int DEF_ADDR_W = 15;
    localparam int DEF_OFF_W  = 3;
    localparam int DEF_IDX_W  = 2;
    localparam int DEF_CNT_W  = 32;

    // Per-set fill-order state
    typedef enum logic [1:0] {
        SET_EMPTY   = 2'd0,
        SET_HALF    = 2'd1,
        SET_FULL_V0 = 2'd2,
        SET_FULL_V1 = 2'd3
    } set_state_e;

endpackage

// File: rtl/fdir_set.sv
module fdir_set
    import fdir_pkg::*;
#(
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic [TAG_W-1:0] tag_in,
    output logic             hit_o,
    output logic             hit_way_o,
    output logic             victim_o
);

    set_state_e       state_q;
    set_state_e       state_d;
    logic [TAG_W-1:0] tag_q [2];
    logic [1:0]       valid;
    logic [1:0]       match;
    logic             fill;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SET_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Tag storage: the victim way takes the new tag on a fill
    always_ff @(posedge clk) begin
        if (fill) begin
            tag_q[victim_o] <= tag_in;
        end
    end

    // Outputs and next state
    always_comb begin
        unique case (state_q)
            SET_EMPTY:   begin valid = 2'b00; victim_o = 1'b0; end
            SET_HALF:    begin valid = 2'b01; victim_o = 1'b1; end
            SET_FULL_V0: begin valid = 2'b11; victim_o = 1'b0; end
            SET_FULL_V1: begin valid = 2'b11; victim_o = 1'b1; end
        endcase

        for (int w = 0; w < 2; w++) begin
            match[w] = valid[w] && (tag_q[w] == tag_in);
        end
        hit_o     = |match;
        hit_way_o = match[1];
        fill      = sel && !hit_o;

        state_d = state_q;
        if (fill) begin
            unique case (state_q)
                SET_EMPTY:   state_d = SET_HALF;
                SET_HALF:    state_d = SET_FULL_V0;
                SET_FULL_V0: state_d = SET_FULL_V1;
                SET_FULL_V1: state_d = SET_FULL_V0;
            endcase
        end
    end

endmodule

// File: rtl/fdir_counter.sv
module fdir_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && (count != TOP)) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/fifo_tag_dir.sv
module fifo_tag_dir
    import fdir_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int OFF_W  = DEF_OFF_W,
    parameter int IDX_W  = DEF_IDX_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              clear_stats,
    output logic              hit,
    output logic              miss,
    output logic [IDX_W-1:0]  set_idx,
    output logic              way,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
    localparam int NUM_SETS = 1 << IDX_W;

    logic [IDX_W-1:0]    idx;
    logic [TAG_W-1:0]    tag;
    logic [NUM_SETS-1:0] sel;
    logic [NUM_SETS-1:0] set_hit;
    logic [NUM_SETS-1:0] set_hway;
    logic [NUM_SETS-1:0] set_vict;

    assign idx     = addr[OFF_W +: IDX_W];
    assign tag     = addr[ADDR_W-1 -: TAG_W];
    assign set_idx = idx;

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        assign sel[g] = req_valid && (idx == IDX_W'(g));
        fdir_set #(.TAG_W(TAG_W)) set_i (
            .clk       (clk),
            .rst       (rst),
            .sel       (sel[g]),
            .tag_in    (tag),
            .hit_o     (set_hit[g]),
            .hit_way_o (set_hway[g]),
            .victim_o  (set_vict[g])
        );
    end

    always_comb begin
        hit  = req_valid && set_hit[idx];
        miss = req_valid && !set_hit[idx];
        if (!req_valid) begin
            way = 1'b0;
        end else if (set_hit[idx]) begin
            way = set_hway[idx];
        end else begin
            way = set_vict[idx];
        end
    end

    fdir_counter #(.W(CNT_W)) hit_cnt_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (clear_stats),
        .inc   (hit),
        .count (hit_count)
    );

    fdir_counter #(.W(CNT_W)) miss_cnt_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (clear_stats),
        .inc   (miss),
        .count (miss_count)
    );

endmodule

// File: rtl/fdir_checker.sv
module fdir_checker #(
    parameter int ADDR_W = 15,
    parameter int OFF_W  = 3,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] addr,
    input logic              clear_stats,
    input logic              hit,
    input logic              miss,
    input logic              way,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);

    localparam logic [CNT_W-1:0] TOP = '1;

    a_r3_one_result: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (hit ^ miss));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!hit && !miss && !way));

    a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (rst)
        (req_valid && miss) ##1
        (req_valid && addr[ADDR_W-1:OFF_W] == $past(addr[ADDR_W-1:OFF_W])) |-> hit);

    a_r9_hit_step: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit && !clear_stats && hit_count != TOP)
        |=> hit_count == $past(hit_count) + CNT_W'(1));

    a_r9_miss_step: assert property (@(posedge clk) disable iff (rst)
        (req_valid && miss && !clear_stats && miss_count != TOP)
        |=> miss_count == $past(miss_count) + CNT_W'(1));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !clear_stats) |=> ($stable(hit_count) && $stable(miss_count)));

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clear_stats |=> (hit_count == '0 && miss_count == '0));

    a_r8_reset_zero: assert property (@(posedge clk)
        rst |=> (hit_count == '0 && miss_count == '0));

endmodule

bind fifo_tag_dir fdir_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .addr        (addr),
    .clear_stats (clear_stats),
    .hit         (hit),
    .miss        (miss),
    .way         (way),
    .hit_count   (hit_count),
    .miss_count  (miss_count)
);

// File: tb/fifo_tag_dir_tb_top.sv
`timescale 1ns/1ps
module fifo_tag_dir_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [14:0] addr = '0;
    logic        clear_stats = 1'b0;
    logic        hit;
    logic        miss;
    logic [1:0]  set_idx;
    logic        way;
    logic [31:0] hit_count;
    logic [31:0] miss_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model: per set, fill count, stored tags, next victim
    int mn [4];
    int mt [4][2];
    int mv [4];

    always #2.5 clk = ~clk;

    fifo_tag_dir dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .addr        (addr),
        .clear_stats (clear_stats),
        .hit         (hit),
        .miss        (miss),
        .set_idx     (set_idx),
        .way         (way),
        .hit_count   (hit_count),
        .miss_count  (miss_count)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 4; s++) begin
            mn[s] = 0;
            mv[s] = 0;
            mt[s][0] = 0;
            mt[s][1] = 0;
        end
    endtask

    // One request; returns the expected hit and way. Result packed as {hit,miss,set,way}.
    task automatic do_access(input int a, input bit clr, input string rq,
                             output bit eh, output int ew);
        int s;
        int t;
        int exp_v;
        int act_v;
        s  = (a >> 3) & 3;
        t  = a >> 5;
        eh = 1'b0;
        ew = 0;
        for (int w = 0; w < mn[s]; w++) begin
            if (mt[s][w] == t) begin
                eh = 1'b1;
                ew = w;
            end
        end
        if (!eh) begin
            if (mn[s] < 2) begin
                ew = mn[s];
                mt[s][ew] = t;
                mn[s]++;
                if (mn[s] == 2) mv[s] = 0;
            end else begin
                ew = mv[s];
                mt[s][ew] = t;
                mv[s] ^= 1;
            end
        end
        @(negedge clk);
        req_valid   = 1'b1;
        addr        = 15'(a);
        clear_stats = clr;
        #1;
        exp_v = {eh, !eh, 2'(s), 1'(ew)};
        act_v = {hit, miss, set_idx, way};
        chk(act_v == exp_v, rq, $sformatf("lookup addr=%0h {hit,miss,set,way}", a),
            act_v, exp_v);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid   = 1'b0;
        clear_stats = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        clear_stats = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        #1;
    endtask

    function automatic int mk(input int t, input int s, input int off);
        return (t << 5) | (s << 3) | off;
    endfunction

    initial begin
        bit eh;
        int ew;
        int hits;
        int misses;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R8 / R3: reset state
        chk(hit_count == 0, "R8", "hit_count after reset", hit_count, 0);
        chk(miss_count == 0, "R8", "miss_count after reset", miss_count, 0);
        chk(!hit && !miss && !way, "R3", "idle outputs", {hit, miss, way}, 0);

        // R1 R2 R4 R5: four passes of a byte sweep
        hits = 0;
        misses = 0;
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a <= 'h43; a++) begin
                do_access(a, 1'b0, "R1/R2/R4/R5", eh, ew);
                if (eh) hits++; else misses++;
            end
        end
        idle();
        chk(hit_count == 254, "R5", "sweep hit total", hit_count, 254);
        chk(miss_count == 18, "R5", "sweep miss total", miss_count, 18);
        chk(hit_count == 32'(hits), "R9", "hit_count vs model", hit_count, hits);
        chk(miss_count == 32'(misses), "R9", "miss_count vs model", miss_count, misses);

        // R3 / R9: idle cycles leave everything still
        repeat (4) idle();
        chk(!hit && !miss && !way, "R3", "idle outputs after sweep", {hit, miss, way}, 0);
        chk(hit_count == 254, "R9", "hit_count held in idle", hit_count, 254);

        // R10: clear together with a request
        do_access('h08, 1'b1, "R10", eh, ew);
        idle();
        chk(hit_count == 0, "R10", "hit_count after clear with request", hit_count, 0);
        chk(miss_count == 0, "R10", "miss_count after clear with request", miss_count, 0);
        do_access('h09, 1'b0, "R9", eh, ew);
        idle();
        chk(hit_count + miss_count == 1, "R9", "one count after one request",
            hit_count + miss_count, 1);

        // R8: reset mid-run empties the directory
        do_reset();
        chk(hit_count == 0 && miss_count == 0, "R8", "counters after mid-run reset",
            hit_count + miss_count, 0);
        do_access('h0C, 1'b0, "R8", eh, ew);
        chk(miss && !way, "R8", "line misses into way 0 after reset", {miss, way}, 2'b10);

        // R6: hit on the older line does not save it from eviction
        do_access(mk(5, 2, 0), 1'b0, "R4", eh, ew);
        chk(way == 1'b0, "R4", "first fill way", way, 0);
        do_access(mk(6, 2, 1), 1'b0, "R4", eh, ew);
        chk(way == 1'b1, "R4", "second fill way", way, 1);
        do_access(mk(5, 2, 7), 1'b0, "R6", eh, ew);
        chk(hit && !way, "R6", "hit on oldest line", {hit, way}, 2'b10);
        do_access(mk(7, 2, 2), 1'b0, "R6", eh, ew);
        chk(miss && !way, "R6", "eviction picks way 0 despite hit", {miss, way}, 2'b10);
        do_access(mk(6, 2, 3), 1'b0, "R6", eh, ew);
        chk(hit && way, "R6", "younger line survives", {hit, way}, 2'b11);
        do_access(mk(8, 2, 4), 1'b0, "R5", eh, ew);
        chk(miss && way, "R5", "next eviction picks way 1", {miss, way}, 2'b11);

        // R7: other sets untouched by the churn in set 2
        do_access('h0D, 1'b0, "R7", eh, ew);
        chk(hit && !way, "R7", "set 1 line still present", {hit, way}, 2'b10);
        do_access(mk(9, 3, 0), 1'b0, "R7", eh, ew);
        chk(miss && !way && set_idx == 2'd3, "R7", "set 3 still empty",
            {miss, way, set_idx}, 4'b1011);

        idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule